// File: doc/BRIEF.md
# Microsecond Event Timer (one-shot / periodic)

This block is one down-counting event timer for a processor. An external strobe, `tick`, pulses once per microsecond, and the timer counts only on cycles where that strobe is high. Software programs the timer with one control word. That word carries the start flag, the repeat flag and the count, all in the same write. The timer raises a level interrupt when it expires. The interrupt stays high until software acknowledges it through a second word, using write-one-to-clear.

The count uses an "n+1" encoding. A loaded value N expires on the (N+1)-th tick, so software writes `delay - 1`. In one-shot mode the timer disables itself when it expires. In repeat mode it reloads the stored value on the expiry tick and runs again, so it fires every N+1 ticks. Each instance decodes a 3-bit byte offset. Instances are therefore placed 8 bytes apart in a shared map, one per processor. The control word sits at offset 0x0 and the status word at offset 0x4.

Top module: `usec_evt_timer`

## Requirements
- R1: After reset `irq` is 0, and reads of both words return 0.
- R2: A write to offset 0x0 with bit 31 set does three things: it stores bits [28:0] as the reload value, stores bit 30 as the repeat flag, and loads the counter with bits [28:0]. This restarts counting even if the timer is already running.
- R3: In one-shot mode (bit 30 = 0) with value N, the timer expires on the (N+1)-th enabled tick. On expiry `irq` goes high, bit 31 of the control word reads 0, and the counter stays at 0 with no further expiry.
- R4: In repeat mode (bit 30 = 1) the counter reloads N on the expiry tick, so the timer expires again every N+1 ticks.
- R5: A write to offset 0x0 with bit 31 clear stops the timer. The remaining count is held, and later ticks neither change it nor cause an expiry. Writing 0 stops the timer.
- R6: Cycles where `tick` is low leave the count unchanged.
- R7: A write to offset 0x4 with bit 30 set clears the pending interrupt. A write to 0x4 with bit 30 clear has no effect.
- R8: If an expiry and a clear write fall in the same cycle, the interrupt stays set.
- R9: If a write to offset 0x0 falls in the same cycle as a tick, the write takes effect and that tick is discarded.
- R10: A read returns data on `rdata` one cycle after `rd_en`, as follows:
  - Offset 0x0 returns enable in bit 31, repeat in bit 30 and the reload value in [28:0].
  - Offset 0x4 returns the pending flag in bit 30 and the remaining count in [28:0].
  - Address bits [1:0] are ignored.
- R11: `irq` is level-high and stays high across later ticks until it is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Microsecond strobe, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Byte offset within the instance |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level-high expiry interrupt |

## Verification
Two pairs of events can fall in the same cycle:
- **Expiry and acknowledge.** The bench leaves an interrupt pending, loads a count of zero, and then drives the expiry tick and a write of bit 30 to offset 0x4 in the same cycle. It judges the result by `irq` staying high and by the status word reading pending with a zero count.
- **Control write and tick.** The bench drives a control write together with a tick. It checks that the counter holds exactly the newly written value, with the tick not applied.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic {
    WORD_CTL  = 1'b0,
    WORD_STAT = 1'b1
  } word_sel_e;

  function automatic word_sel_e decode_word(input logic sel);
    return sel ? WORD_STAT : WORD_CTL;
  endfunction
endpackage

// File: rtl/evt_timer_regif.sv
module evt_timer_regif
  import evt_timer_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 29,
  parameter int EN_BIT  = 31,
  parameter int PER_BIT = 30,
  parameter int CLR_BIT = 30,
  parameter int SEL_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cur_en,
  input  logic              cur_per,
  input  logic [CNT_W-1:0]  cur_reload,
  input  logic [CNT_W-1:0]  cur_cnt,
  input  logic              cur_pend,
  output logic              ctl_wr,
  output logic              ctl_en,
  output logic              ctl_per,
  output logic [CNT_W-1:0]  ctl_val,
  output logic              clr_req,
  output logic [DATA_W-1:0] rdata
);
  word_sel_e   sel;
  logic [DATA_W-1:0] rd_word;

  assign sel     = decode_word(addr[SEL_BIT]);
  assign ctl_wr  = wr_en && (sel == WORD_CTL);
  assign ctl_en  = wdata[EN_BIT];
  assign ctl_per = wdata[PER_BIT];
  assign ctl_val = wdata[CNT_W-1:0];
  assign clr_req = wr_en && (sel == WORD_STAT) && wdata[CLR_BIT];

  always_comb begin
    rd_word = '0;
    if (sel == WORD_CTL) begin
      rd_word[EN_BIT]    = cur_en;
      rd_word[PER_BIT]   = cur_per;
      rd_word[CNT_W-1:0] = cur_reload;
    end else begin
      rd_word[CLR_BIT]   = cur_pend;
      rd_word[CNT_W-1:0] = cur_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ctl_wr,
  input  logic             ctl_en,
  input  logic             ctl_per,
  input  logic [CNT_W-1:0] ctl_val,
  output logic             en,
  output logic             per,
  output logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic at_zero;
  logic step;

  assign at_zero = (cnt == '0);
  // A control write in the same cycle swallows the tick.
  assign step    = tick && en && !ctl_wr;
  assign expire  = step && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      per    <= 1'b0;
      reload <= '0;
      cnt    <= '0;
    end else if (ctl_wr) begin
      en     <= ctl_en;
      per    <= ctl_per;
      reload <= ctl_val;
      if (ctl_en) cnt <= ctl_val;
    end else if (step) begin
      if (at_zero) begin
        if (per) cnt <= reload;
        else     en  <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic clr_req,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst)          pend <= 1'b0;
    else if (expire)  pend <= 1'b1;
    else if (clr_req) pend <= 1'b0;
  end
endmodule

// File: rtl/usec_evt_timer.sv
module usec_evt_timer #(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 29,
  parameter int EN_BIT  = 31,
  parameter int PER_BIT = 30,
  parameter int CLR_BIT = 30,
  parameter int SEL_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic             ctl_wr, ctl_en, ctl_per, clr_req, expire;
  logic [CNT_W-1:0] ctl_val;
  logic             tmr_en, tmr_per, pend;
  logic [CNT_W-1:0] tmr_reload, tmr_cnt;

  evt_timer_regif #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .EN_BIT(EN_BIT),
    .PER_BIT(PER_BIT), .CLR_BIT(CLR_BIT), .SEL_BIT(SEL_BIT)
  ) regif_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cur_en(tmr_en), .cur_per(tmr_per),
    .cur_reload(tmr_reload), .cur_cnt(tmr_cnt), .cur_pend(pend),
    .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_per(ctl_per), .ctl_val(ctl_val),
    .clr_req(clr_req), .rdata(rdata)
  );

  evt_timer_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst(rst), .tick(tick), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
    .ctl_per(ctl_per), .ctl_val(ctl_val), .en(tmr_en), .per(tmr_per),
    .reload(tmr_reload), .cnt(tmr_cnt), .expire(expire)
  );

  evt_timer_irq irq_i (
    .clk(clk), .rst(rst), .expire(expire), .clr_req(clr_req), .pend(pend)
  );

  assign irq = pend;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             ctl_wr,
  input logic             clr_req,
  input logic             expire,
  input logic             en,
  input logic             per,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             irq
);
  a_r3_oneshot_stops: assert property (@(posedge clk) disable iff (rst)
    expire && !per |=> !en && (cnt == '0));

  a_r4_periodic_reload: assert property (@(posedge clk) disable iff (rst)
    expire && per |=> en && (cnt == $past(reload)));

  a_r5_idle_no_expiry: assert property (@(posedge clk) disable iff (rst)
    !en |-> !expire);

  a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick && !ctl_wr |=> $stable(cnt));

  a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
    clr_req && !expire |=> !irq);

  a_r8_expiry_wins: assert property (@(posedge clk) disable iff (rst)
    expire |=> irq);

  a_r11_irq_holds: assert property (@(posedge clk) disable iff (rst)
    irq && !clr_req |=> irq);
endmodule

bind usec_evt_timer evt_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .ctl_wr(ctl_wr), .clr_req(clr_req),
  .expire(expire), .en(tmr_en), .per(tmr_per), .cnt(tmr_cnt),
  .reload(tmr_reload), .irq(irq)
);

// File: tb/usec_evt_timer_tb_top.sv
module usec_evt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  usec_evt_timer dut_i (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // One clock: drive after a falling edge, return at the next falling edge.
  task automatic cyc(input logic t, input logic w, input logic r,
                     input logic [2:0] a, input logic [31:0] d);
    tick = t; wr_en = w; rd_en = r; addr = a; wdata = d;
    @(negedge clk);
    tick = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(0, 1, 0, a, d);
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
    cyc(0, 0, 1, a, '0);
    check(req, rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 3'd0, '0);
  endtask

  task automatic t_reset;
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd_check("R1 ctl", 3'd0, 32'd0);
    rd_check("R1 stat", 3'd4, 32'd0);
  endtask

  task automatic t_oneshot;
    wr(3'd0, 32'h8000_0003);
    rd_check("R2 ctl", 3'd0, 32'h8000_0003);
    rd_check("R10 stat ignores addr[1:0]", 3'd7, 32'h0000_0003);
    ticks(3);
    check("R3 no early irq", {31'd0, irq}, 32'd0);
    rd_check("R3 still enabled", 3'd0, 32'h8000_0003);
    ticks(1);
    check("R3 irq on N+1", {31'd0, irq}, 32'd1);
    rd_check("R3 enable cleared", 3'd0, 32'h0000_0003);
    ticks(5);
    check("R11 irq held", {31'd0, irq}, 32'd1);
    rd_check("R3 count stays 0", 3'd4, 32'h4000_0000);
    wr(3'd4, 32'hBFFF_FFFF);
    check("R7 no clear without bit30", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'h4000_0000);
    check("R7 clear", {31'd0, irq}, 32'd0);
    ticks(4);
    check("R3 no re-fire", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_periodic;
    wr(3'd0, 32'hC000_0002);
    ticks(2);
    check("R4 no early irq", {31'd0, irq}, 32'd0);
    ticks(1);
    check("R4 first expiry", {31'd0, irq}, 32'd1);
    rd_check("R4 reloaded", 3'd4, 32'h4000_0002);
    wr(3'd4, 32'h4000_0000);
    ticks(2);
    check("R4 mid period", {31'd0, irq}, 32'd0);
    ticks(1);
    check("R4 second expiry", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'h4000_0000);
    wr(3'd0, 32'h0);
    rd_check("R5 zero write stops", 3'd0, 32'h0);
  endtask

  task automatic t_stop_hold;
    wr(3'd0, 32'h8000_0005);
    ticks(2);
    wr(3'd0, 32'h0);
    rd_check("R5 count held", 3'd4, 32'h0000_0003);
    ticks(10);
    rd_check("R5 no counting", 3'd4, 32'h0000_0003);
    check("R5 no irq", {31'd0, irq}, 32'd0);
    wr(3'd0, 32'h8000_0007);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 3'd0, '0);
    rd_check("R6 stable without tick", 3'd4, 32'h0000_0007);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_restart_collide;
    wr(3'd0, 32'h8000_0004);
    ticks(2);
    rd_check("R2 counting", 3'd4, 32'h0000_0002);
    wr(3'd0, 32'h8000_0006);
    rd_check("R2 restart", 3'd4, 32'h0000_0006);
    cyc(1, 1, 0, 3'd0, 32'h8000_0001);
    rd_check("R9 tick discarded", 3'd4, 32'h0000_0001);
    ticks(1);
    check("R9 not yet", {31'd0, irq}, 32'd0);
    ticks(1);
    check("R9 expiry", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_expire_vs_clear;
    wr(3'd0, 32'h8000_0000);
    check("R8 pending kept over load", {31'd0, irq}, 32'd1);
    cyc(1, 1, 0, 3'd4, 32'h4000_0000);
    check("R8 expiry beats clear", {31'd0, irq}, 32'd1);
    rd_check("R8 stat", 3'd4, 32'h4000_0000);
    wr(3'd4, 32'h4000_0000);
    check("R7 clear after", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_oneshot();
    t_periodic();
    t_stop_hold();
    t_restart_collide();
    t_expire_vs_clear();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule